// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the register-programming side of a classic eight-input interrupt controller. A processor talks to it over a byte-wide bus with two addresses, a command port and a data port. Each port has its own write strobe and read strobe. After a setup word on the command port, the block expects a short run of data-port writes. How many it expects depends on the setup word. It captures the vector base, the cascade byte and the automatic end-of-interrupt choice, then returns to normal operation.

In normal operation the data port holds the interrupt mask. Command writes either arm a one-shot selection that makes the next command read return the in-service bits, or issue end-of-interrupt commands. The in-service and request registers live outside this block. For an end-of-interrupt command the block takes the current in-service value, clears the chosen bits and returns the updated value with a one-cycle valid pulse. Priority resolution, acknowledge cycles and cascading are done by neighbouring logic.

All inputs are sampled on the rising clock edge, and reset is synchronous and active high. At most one strobe is expected per cycle. If both write strobes are high together, the command write wins and the data write is dropped.

Top module: `irqc_prog_front`

## Requirements
- R1: After reset the mask, cascade byte, vector-valid flag and auto-EOI flag are zero and the block is not in setup. A command read returns `req_in`.
- R2: A command write with bit 4 set (setup word) enters setup on the next cycle. It stores the whole byte as `cfg_q`, drops `vec_ok` and drops `casc_ok`.
- R3: The first data write in setup stores `wdata & 8'hF8` as `vec_base` and raises `vec_ok`.
- R4: When `cfg_q` bit 1 is 1 (single controller) and bit 0 is 0 (no mode word), setup ends right after the vector write.
- R5: When `cfg_q` bit 1 is 0 (cascaded), the data write after the vector is stored as `casc_q` and `casc_ok` rises. Setup then ends if bit 0 is 0. `casc_q` never changes outside setup.
- R6: The last data write in setup is the mode word. Its bit 1 sets `auto_eoi`, its other bits have no effect, and setup ends. `auto_eoi` is cleared only by reset.
- R7: Outside setup a data write loads `mask_q`. A data read gives `mask_q` on `rdata`, with `rd_vld` high, one cycle after the strobe.
- R8: A command write of exactly 8'h0B arms a one-shot selection. The next command read returns `svc_in` and disarms it, while any other command read returns `req_in`. No other command value arms it.
- R9: A command write with bits 4 and 3 clear and bit 5 set is an end-of-interrupt. On the next cycle `isr_upd_vld` pulses and `isr_upd` is `svc_in` with bit `wdata[2:0]` cleared when bit 6 is set, or with all bits cleared when bit 6 is clear. Without bit 5 there is no pulse.
- R10: Data writes during setup leave `mask_q` unchanged.
- R11: A setup word received during setup restarts the sequence from the vector write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_rd | input | 1 | Command port read strobe |
| dat_wr | input | 1 | Data port write strobe |
| dat_rd | input | 1 | Data port read strobe |
| wdata | input | 8 | Write data |
| req_in | input | 8 | External request register |
| svc_in | input | 8 | External in-service register |
| rdata | output | 8 | Registered read data |
| rd_vld | output | 1 | Read data valid, one cycle after a read strobe |
| mask_q | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| vec_ok | output | 1 | Vector base written since the last setup word |
| casc_q | output | 8 | Cascade byte |
| casc_ok | output | 1 | Cascade byte written since the last setup word |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| in_init | output | 1 | Setup sequence in progress |
| cfg_q | output | 8 | Stored setup word |
| isr_upd | output | 8 | Updated in-service value after an end-of-interrupt |
| isr_upd_vld | output | 1 | One-cycle pulse qualifying `isr_upd` |

## Verification
Several properties are checked on every cycle. A setup word always lands in setup with the vector invalid. Single-mode setup without a mode word always stops after the vector. The mask and cascade byte hold whenever a write to them is not allowed. `auto_eoi` never falls outside reset. An end-of-interrupt result never sets a bit that was clear in the in-service input. The one-shot selection is always gone after a command read. Only the bench scenarios can show which words each setup variant consumes and what values it stores. They also show that a restart mid-sequence behaves correctly, that the read data comes from the correct source on each read, and that a specific-level clear hits the indexed bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 8;
    localparam int LVL_W  = $clog2(DATA_W);

    // command word flags
    localparam int BIT_SETUP     = 4;
    localparam int BIT_OCW3      = 3;
    localparam int BIT_EOI       = 5;
    localparam int BIT_SPECIFIC  = 6;
    // setup word fields
    localparam int BIT_NEED_MODE = 0;
    localparam int BIT_SINGLE    = 1;
    // mode word field
    localparam int BIT_AUTO_EOI  = 1;

    localparam logic [DATA_W-1:0] CODE_READ_SVC = 8'h0B;
    localparam logic [DATA_W-1:0] VEC_KEEP      = 8'hF8;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_VEC  = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } setup_st_e;

    typedef enum logic [1:0] {
        CW_SETUP = 2'd0,
        CW_OCW3  = 2'd1,
        CW_OCW2  = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic             eoi;
        logic             specific;
        logic [LVL_W-1:0] level;
    } eoi_cmd_t;

    function automatic cmd_kind_e classify(input logic [DATA_W-1:0] d);
        if (d[BIT_SETUP])     return CW_SETUP;
        else if (d[BIT_OCW3]) return CW_OCW3;
        else                  return CW_OCW2;
    endfunction

    function automatic eoi_cmd_t decode_eoi(input logic [DATA_W-1:0] d);
        eoi_cmd_t c;
        c.eoi      = d[BIT_EOI];
        c.specific = d[BIT_SPECIFIC];
        c.level    = d[LVL_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] clear_bits(input eoi_cmd_t c);
        logic [DATA_W-1:0] m;
        if (c.specific) begin
            m = '0;
            m[c.level] = 1'b1;
        end else begin
            m = '1;
        end
        return m;
    endfunction

    function automatic setup_st_e after_vector(input logic [DATA_W-1:0] cfg);
        if (!cfg[BIT_SINGLE])        return ST_CASC;
        else if (cfg[BIT_NEED_MODE]) return ST_MODE;
        else                         return ST_RUN;
    endfunction

endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              in_init,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] vec_base,
    output logic              vec_ok,
    output logic [DATA_W-1:0] casc_q,
    output logic              casc_ok,
    output logic              auto_eoi
);

    setup_st_e st_q;
    logic      setup_hit;
    logic      word_in;

    assign setup_hit = cmd_wr && (classify(wdata) == CW_SETUP);
    assign word_in   = dat_wr && !cmd_wr;
    assign in_init   = (st_q != ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_RUN;
            cfg_q    <= '0;
            vec_base <= '0;
            vec_ok   <= 1'b0;
            casc_q   <= '0;
            casc_ok  <= 1'b0;
            auto_eoi <= 1'b0;
        end else if (setup_hit) begin
            st_q    <= ST_VEC;
            cfg_q   <= wdata;
            vec_ok  <= 1'b0;
            casc_ok <= 1'b0;
        end else if (word_in) begin
            unique case (st_q)
                ST_VEC: begin
                    vec_base <= wdata & VEC_KEEP;
                    vec_ok   <= 1'b1;
                    st_q     <= after_vector(cfg_q);
                end
                ST_CASC: begin
                    casc_q  <= wdata;
                    casc_ok <= 1'b1;
                    st_q    <= cfg_q[BIT_NEED_MODE] ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    if (wdata[BIT_AUTO_EOI]) auto_eoi <= 1'b1;
                    st_q <= ST_RUN;
                end
                default: ;
            endcase
        end
    end

    AST_SETUP_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[BIT_SETUP]) |=> (in_init && !vec_ok)); // R2

    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (word_in && st_q == ST_VEC && cfg_q[BIT_SINGLE] && !cfg_q[BIT_NEED_MODE])
        |=> !in_init); // R4

    AST_CASC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_init |=> $stable(casc_q)); // R5

    AST_AUTO_EOI_STICKY: assert property (@(posedge clk) disable iff (rst)
        auto_eoi |=> auto_eoi); // R6

endmodule

// File: rtl/irqc_op_words.sv
module irqc_op_words
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              in_init,
    input  logic [DATA_W-1:0] svc_in,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] isr_upd,
    output logic              isr_upd_vld
);

    eoi_cmd_t eoi_c;
    logic     eoi_hit;

    assign eoi_c   = decode_eoi(wdata);
    assign eoi_hit = cmd_wr && (classify(wdata) == CW_OCW2) && eoi_c.eoi;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (dat_wr && !cmd_wr && !in_init) begin
            mask_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_upd     <= '0;
            isr_upd_vld <= 1'b0;
        end else begin
            isr_upd_vld <= eoi_hit;
            if (eoi_hit) isr_upd <= svc_in & ~clear_bits(eoi_c);
        end
    end

    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        in_init |=> $stable(mask_q)); // R10

    AST_EOI_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        isr_upd_vld |-> ((isr_upd & ~$past(svc_in)) == '0)); // R9

endmodule

// File: rtl/irqc_read_port.sv
module irqc_read_port
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic              dat_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] req_in,
    input  logic [DATA_W-1:0] svc_in,
    input  logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_vld
);

    logic svc_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_sel_q <= 1'b0;
        end else if (cmd_wr && wdata == CODE_READ_SVC) begin
            svc_sel_q <= 1'b1;
        end else if (cmd_rd) begin
            svc_sel_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= cmd_rd || dat_rd;
            if (cmd_rd)      rdata <= svc_sel_q ? svc_in : req_in;
            else if (dat_rd) rdata <= mask_q;
        end
    end

    AST_SELECT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd && !cmd_wr) |=> !svc_sel_q); // R8

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd || dat_rd) |=> rd_vld); // R7

endmodule

// File: rtl/irqc_prog_front.sv
module irqc_prog_front
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] req_in,
    input  logic [DATA_W-1:0] svc_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_vld,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] vec_base,
    output logic              vec_ok,
    output logic [DATA_W-1:0] casc_q,
    output logic              casc_ok,
    output logic              auto_eoi,
    output logic              in_init,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] isr_upd,
    output logic              isr_upd_vld
);

    irqc_init_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .dat_wr   (dat_wr),
        .wdata    (wdata),
        .in_init  (in_init),
        .cfg_q    (cfg_q),
        .vec_base (vec_base),
        .vec_ok   (vec_ok),
        .casc_q   (casc_q),
        .casc_ok  (casc_ok),
        .auto_eoi (auto_eoi)
    );

    irqc_op_words u_ops (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr),
        .dat_wr      (dat_wr),
        .wdata       (wdata),
        .in_init     (in_init),
        .svc_in      (svc_in),
        .mask_q      (mask_q),
        .isr_upd     (isr_upd),
        .isr_upd_vld (isr_upd_vld)
    );

    irqc_read_port u_rd (
        .clk    (clk),
        .rst    (rst),
        .cmd_wr (cmd_wr),
        .cmd_rd (cmd_rd),
        .dat_rd (dat_rd),
        .wdata  (wdata),
        .req_in (req_in),
        .svc_in (svc_in),
        .mask_q (mask_q),
        .rdata  (rdata),
        .rd_vld (rd_vld)
    );

    AST_ICW_NO_RESET_INIT: assert property (@(posedge clk)
        $past(rst) |-> (!in_init && mask_q == '0 && !auto_eoi)); // R1

endmodule

// File: tb/irqc_prog_front_tb_top.sv
`timescale 1ns/1ps
module irqc_prog_front_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_wr = 0, cmd_rd = 0, dat_wr = 0, dat_rd = 0;
    logic [7:0] wdata = '0, req_in = '0, svc_in = '0;
    logic [7:0] rdata, mask_q, vec_base, casc_q, cfg_q, isr_upd;
    logic       rd_vld, vec_ok, casc_ok, auto_eoi, in_init, isr_upd_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        bit         is_read;
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    irqc_prog_front dut_i (
        .clk(clk), .rst(rst),
        .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .wdata(wdata), .req_in(req_in), .svc_in(svc_in),
        .rdata(rdata), .rd_vld(rd_vld), .mask_q(mask_q),
        .vec_base(vec_base), .vec_ok(vec_ok), .casc_q(casc_q), .casc_ok(casc_ok),
        .auto_eoi(auto_eoi), .in_init(in_init), .cfg_q(cfg_q),
        .isr_upd(isr_upd), .isr_upd_vld(isr_upd_vld)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input bit is_read, input logic [7:0] v, input string req);
        exp_t e;
        e.is_read = is_read;
        e.val     = v;
        e.req     = req;
        sb_q.push_back(e);
    endtask

    task automatic cmd_write(input logic [7:0] d);
        @(negedge clk); cmd_wr = 1; wdata = d;
        @(negedge clk); cmd_wr = 0;
    endtask

    task automatic dat_write(input logic [7:0] d);
        @(negedge clk); dat_wr = 1; wdata = d;
        @(negedge clk); dat_wr = 0;
    endtask

    task automatic cmd_read(input logic [7:0] exp, input string req);
        @(negedge clk); cmd_rd = 1; push(1, exp, req);
        @(negedge clk); cmd_rd = 0;
    endtask

    task automatic dat_read(input logic [7:0] exp, input string req);
        @(negedge clk); dat_rd = 1; push(1, exp, req);
        @(negedge clk); dat_rd = 0;
    endtask

    // monitor: compare each produced result against the scoreboard head
    always @(negedge clk) begin
        if (!rst && (rd_vld || isr_upd_vld)) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9: actual unexpected result %h expected none",
                         rd_vld ? rdata : isr_upd);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (e.is_read != rd_vld) begin
                    n_fail++;
                    $display("FAIL %s: actual kind %0d expected kind %0d", e.req, rd_vld, e.is_read);
                end else if ((rd_vld ? rdata : isr_upd) !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", e.req,
                             rd_vld ? rdata : isr_upd, e.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 mask", mask_q, 8'h00);
        chk("R1 casc", casc_q, 8'h00);
        chk("R1 flags", {5'b0, in_init, auto_eoi, vec_ok}, 8'h00);
        req_in = 8'h5A; svc_in = 8'hA5;
        cmd_read(8'h5A, "R1 cmd read gives request");

        // R7 mask write and read
        dat_write(8'hC3);
        chk("R7 mask", mask_q, 8'hC3);
        dat_read(8'hC3, "R7 data read");

        // R2 R3 R6: single with mode word
        cmd_write(8'h13);
        chk("R2 cfg", cfg_q, 8'h13);
        chk("R2 in_init/vec_ok", {6'b0, in_init, vec_ok}, 8'h02);
        dat_write(8'h2F);
        chk("R3 vec", vec_base, 8'h28);
        chk("R3 vec_ok/in_init", {6'b0, vec_ok, in_init}, 8'h03);
        dat_write(8'h02);
        chk("R6 auto_eoi/in_init", {6'b0, auto_eoi, in_init}, 8'h02);
        chk("R10 mask kept", mask_q, 8'hC3);
        dat_read(8'hC3, "R10 mask kept read");

        // R4 single without mode word
        cmd_write(8'h12);
        dat_write(8'h47);
        chk("R4 vec", vec_base, 8'h40);
        chk("R4 in_init", {7'b0, in_init}, 8'h00);
        chk("R6 auto_eoi sticky", {7'b0, auto_eoi}, 8'h01);

        // R5 cascade with mode word
        cmd_write(8'h11);
        chk("R5 casc_ok cleared", {7'b0, casc_ok}, 8'h00);
        dat_write(8'h70);
        chk("R5 still in setup", {7'b0, in_init}, 8'h01);
        dat_write(8'h04);
        chk("R5 casc", casc_q, 8'h04);
        chk("R5 casc_ok/in_init", {6'b0, casc_ok, in_init}, 8'h03);
        dat_write(8'hFD);
        chk("R6 mode word other bits", {6'b0, auto_eoi, in_init}, 8'h02);
        chk("R6 casc untouched", casc_q, 8'h04);

        // R5 cascade without mode word
        cmd_write(8'h10);
        dat_write(8'h08);
        dat_write(8'h02);
        chk("R5 casc no mode", casc_q, 8'h02);
        chk("R5 ends", {7'b0, in_init}, 8'h00);
        dat_write(8'h99);
        chk("R5 casc hold outside setup", casc_q, 8'h02);
        chk("R7 mask after setup", mask_q, 8'h99);

        // R11 restart mid-sequence
        cmd_write(8'h13);
        dat_write(8'h50);
        chk("R11 first vec", vec_base, 8'h50);
        cmd_write(8'h12);
        chk("R11 restart", {6'b0, in_init, vec_ok}, 8'h02);
        dat_write(8'h66);
        chk("R11 vec", vec_base, 8'h60);
        chk("R11 ends", {7'b0, in_init}, 8'h00);

        // R8 one-shot select
        req_in = 8'h11; svc_in = 8'hA4;
        cmd_write(8'h0B);
        cmd_read(8'hA4, "R8 armed read");
        cmd_read(8'h11, "R8 disarmed read");
        cmd_write(8'h0A);
        cmd_read(8'h11, "R8 other code no arm");

        // R9 end-of-interrupt
        svc_in = 8'hFF;
        @(negedge clk); cmd_wr = 1; wdata = 8'h63; push(0, 8'hF7, "R9 specific level 3");
        @(negedge clk); cmd_wr = 0;
        @(negedge clk); cmd_wr = 1; wdata = 8'h20; push(0, 8'h00, "R9 clear all");
        @(negedge clk); cmd_wr = 0;
        svc_in = 8'h81;
        @(negedge clk); cmd_wr = 1; wdata = 8'h67; push(0, 8'h01, "R9 specific level 7");
        @(negedge clk); cmd_wr = 0;
        cmd_write(8'h42);
        @(negedge clk);
        chk("R9 no eoi no pulse", {7'b0, isr_upd_vld}, 8'h00);
        chk("R9 mask untouched", mask_q, 8'h99);

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", 8'(sb_q.size()), 8'h00);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule